// File: doc/BRIEF.md
# Addressable Bit Latch with Decode Mode

This block keeps a small word of single-bit storage cells. Any one cell can be written through a bit-select address and a single data input. Two active-low control inputs choose what happens on each rising clock edge:

- **clear**: all cells go to zero.
- **decode**: the selected cell takes the data bit and every other cell is forced to zero.
- **addressed write**: only the selected cell is updated.
- **hold**: nothing changes.

All cells drive the output in parallel. Writing one bit per cycle at successive addresses therefore turns a serial stream into a parallel word. With the data input tied high, decode mode acts as a one-hot decoder of the address.

The controls, address and data are sampled at each rising edge, and the stored word changes at that same edge. A caller that keeps the enable low over several cycles sees the selected cell follow the data input on each of them. The value that stays in the cell is the data level sampled on the last enabled cycle. The address should be held steady while the enable is active, unless the caller wants to write more than one cell.

Top module: `bit_addr_latch`

## Requirements
- R1: With clrN low and enN high at a clock edge, every bit of q is zero after that edge, whatever dIn and sel are.
- R2: With clrN and enN both low at a clock edge, bit sel of q equals dIn after that edge, and every other bit is zero.
- R3: In decode mode with dIn high, exactly one bit of q is set (bit sel). With dIn low, q becomes all zero.
- R4: With clrN high and enN low at a clock edge, bit sel of q takes dIn and every other bit keeps its previous value.
- R5: With clrN and enN both high at a clock edge, q is unchanged, whatever dIn and sel are.
- R6: q changes only at a rising clock edge. A new input pattern applied between edges has no effect on q until the next edge.
- R7: Address value k selects q[k], with sel bit 0 as the least significant bit (for example, sel = 3 addresses q[3], weight 8'h08).
- R8: If enN is held low for several cycles in write mode, the selected bit follows dIn on each of those edges. Once enN returns high, the bit keeps the last sampled dIn.
- R9: Eight addressed writes at sel = 0..7, carrying the bits of a word from LSB to MSB, leave that word on q.
- R10: After a decode, a switch to hold mode keeps the one-hot pattern on q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Active-low master clear control |
| enN | input | 1 | Active-low enable |
| dIn | input | 1 | Data bit to store |
| sel | input | SEL_W (3) | Bit-select address, bit 0 is LSB |
| q | output | WIDTH (8) | Parallel stored word |

## Verification
The bench drives every address in decode mode with both data levels. A design that did not clear the unaddressed cells would leave stale ones beside the decoded bit. A reversed or offset address would light the wrong position. Addressed writes are mixed with random neighbour contents, so a write that disturbs other cells, or a hold that reacts to data or address, shows up as a wrong word. The directed sequences cover a serial eight-bit shift-in, an enable held low over several cycles, a decode followed by hold, and an input change between edges. Together they expose designs that latch at the wrong cycle, keep an early data value instead of the last one, or lose the decoded pattern.

// File: rtl/bit_addr_latch_pkg.sv
package bit_addr_latch_pkg;

  // Operating mode chosen by the two active-low controls
  typedef enum logic [1:0] {
    MODE_DECODE = 2'b00,  // clear low, enable low
    MODE_CLEAR  = 2'b01,  // clear low, enable high
    MODE_WRITE  = 2'b10,  // clear high, enable low
    MODE_HOLD   = 2'b11   // clear high, enable high
  } latchMode_t;

  // Strobes from control to datapath; all low means hold
  typedef struct packed {
    logic clearAll;
    logic decodeLoad;
    logic bitWrite;
  } latchStrobes_t;

endpackage

// File: rtl/bit_addr_latch_ctrl.sv
module bit_addr_latch_ctrl
  import bit_addr_latch_pkg::*;
(
  input  logic          clrN,
  input  logic          enN,
  output latchStrobes_t strb
);

  latchMode_t mode;

  assign mode = latchMode_t'({clrN, enN});

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_CLEAR:  strb.clearAll   = 1'b1;
      MODE_DECODE: strb.decodeLoad = 1'b1;
      MODE_WRITE:  strb.bitWrite   = 1'b1;
      MODE_HOLD:   strb           = '0;
      default:     strb           = '0;
    endcase
  end

endmodule

// File: rtl/bit_addr_latch_dp.sv
module bit_addr_latch_dp
  import bit_addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  latchStrobes_t    strb,
  input  logic             dIn,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] nextStore;
  logic [WIDTH-1:0] hit;

  // One next-state slice per cell
  for (genvar k = 0; k < WIDTH; k++) begin : gCell
    assign hit[k] = (sel == SEL_W'(k));

    always_comb begin
      if (strb.clearAll) begin
        nextStore[k] = 1'b0;
      end else if (strb.decodeLoad) begin
        nextStore[k] = hit[k] & dIn;
      end else if (strb.bitWrite && hit[k]) begin
        nextStore[k] = dIn;
      end else begin
        nextStore[k] = store[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    store <= nextStore;
  end

  assign q = store;

endmodule

// File: rtl/bit_addr_latch.sv
module bit_addr_latch
  import bit_addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             enN,
  input  logic             dIn,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] q
);

  latchStrobes_t strb;

  bit_addr_latch_ctrl uCtrl (
    .clrN (clrN),
    .enN  (enN),
    .strb (strb)
  );

  bit_addr_latch_dp #(
    .WIDTH (WIDTH),
    .SEL_W (SEL_W)
  ) uDp (
    .clk  (clk),
    .strb (strb),
    .dIn  (dIn),
    .sel  (sel),
    .q    (q)
  );

endmodule

// File: rtl/bit_addr_latch_chk.sv
module bit_addr_latch_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             clrN,
  input logic             enN,
  input logic             dIn,
  input logic [SEL_W-1:0] sel,
  input logic [WIDTH-1:0] q
);

  // Stays low until two edges have passed, so $past never sees pre-clock values
  logic [1:0] warm = 2'd0;
  logic       live;

  always_ff @(posedge clk) begin
    if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign live = (warm >= 2'd2);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!live)
    (!clrN && enN) |=> (q == '0)); // R1

  AST_DECODE_PATTERN: assert property (@(posedge clk) disable iff (!live)
    (!clrN && !enN) |=> (q == (WIDTH'($past(dIn)) << $past(sel)))); // R2

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!live)
    (!clrN && !enN && dIn) |=> ($countones(q) == 1)); // R3

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!live)
    (clrN && !enN) |=> (q[$past(sel)] == $past(dIn))); // R4

  AST_WRITE_OTHERS: assert property (@(posedge clk) disable iff (!live)
    (clrN && !enN) |=> ((q & ~(WIDTH'(1) << $past(sel))) ==
                        ($past(q) & ~(WIDTH'(1) << $past(sel))))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!live)
    (clrN && enN) |=> $stable(q)); // R5

endmodule

bind bit_addr_latch bit_addr_latch_chk #(
  .WIDTH (WIDTH),
  .SEL_W (SEL_W)
) uChk (
  .clk  (clk),
  .clrN (clrN),
  .enN  (enN),
  .dIn  (dIn),
  .sel  (sel),
  .q    (q)
);

// File: tb/sim_bit_addr_latch.sv
`timescale 1ns/1ps
module sim_bit_addr_latch;

  localparam int WIDTH = 8;
  localparam int SEL_W = 3;

  logic             clk = 1'b0;
  logic             clrN = 1'b0;
  logic             enN = 1'b1;
  logic             dIn = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [WIDTH-1:0] q;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bit_addr_latch #(.WIDTH(WIDTH)) u0 (
    .clk (clk), .clrN (clrN), .enN (enN), .dIn (dIn), .sel (sel), .q (q)
  );

  function automatic logic [WIDTH-1:0] nextQ(logic [WIDTH-1:0] cur, logic c,
                                             logic e, logic d, logic [SEL_W-1:0] s);
    logic [WIDTH-1:0] r;
    r = cur;
    case ({c, e})
      2'b01: r = '0;
      2'b00: begin r = '0; r[s] = d; end
      2'b10: r[s] = d;
      default: r = cur;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [WIDTH-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q=%h expected=%h at %0t", tag, q, exp, $time);
    end
  endtask

  // Called at a negedge: apply inputs, pass one rising edge, return at the next negedge
  task automatic step(logic c, logic e, logic d, logic [SEL_W-1:0] s);
    clrN = c; enN = e; dIn = d; sel = s;
    @(posedge clk);
    model = nextQ(model, c, e, d, s);
    @(negedge clk);
  endtask

  function automatic string modeTag(logic c, logic e);
    case ({c, e})
      2'b01: return "R1";
      2'b00: return "R2";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired q=%h expected=done", q);
    finishRun();
  end

  initial begin
    int unsigned seed;
    logic [WIDTH-1:0] word;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk);

    // Reset state via clear mode, with noise on data and address (R1)
    step(1'b0, 1'b1, 1'b1, 3'd6);
    check("R1 clear state", 8'h00);

    // Decode each address with data high, then low (R2, R3, R7)
    for (int k = 0; k < WIDTH; k++) begin
      step(1'b0, 1'b0, 1'b1, SEL_W'(k));
      check("R3 decode one-hot", WIDTH'(1) << k);
      step(1'b0, 1'b0, 1'b0, SEL_W'(k));
      check("R2 decode data low", 8'h00);
    end

    // Decode then hold keeps the pattern (R10)
    step(1'b0, 1'b0, 1'b1, 3'd5);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b0, SEL_W'(i));
      check("R10 hold after decode", 8'h20);
    end

    // Address weight: sel=3 sets 8'h08 from empty (R7)
    step(1'b0, 1'b1, 1'b0, 3'd0);
    step(1'b1, 1'b0, 1'b1, 3'd3);
    check("R7 address weight", 8'h08);

    // No change between edges (R6)
    clrN = 1'b1; enN = 1'b0; dIn = 1'b1; sel = 3'd0;
    #2;
    check("R6 no change before edge", 8'h08);
    @(posedge clk);
    model = nextQ(model, 1'b1, 1'b0, 1'b1, 3'd0);
    @(negedge clk);
    check("R6 update at edge", 8'h09);

    // Enable held low: bit tracks data, keeps last value (R8)
    step(1'b1, 1'b0, 1'b1, 3'd6);
    check("R8 track high", 8'h49);
    step(1'b1, 1'b0, 1'b0, 3'd6);
    check("R8 track low", 8'h09);
    step(1'b1, 1'b0, 1'b1, 3'd6);
    step(1'b1, 1'b1, 1'b0, 3'd6);
    check("R8 keep last", 8'h49);

    // Serial shift-in of a word (R9)
    word = 8'hA5;
    step(1'b0, 1'b1, 1'b0, 3'd0);
    for (int k = 0; k < WIDTH; k++) step(1'b1, 1'b0, word[k], SEL_W'(k));
    check("R9 serial word", 8'hA5);
    word = 8'h3C;
    for (int k = 0; k < WIDTH; k++) step(1'b1, 1'b0, word[k], SEL_W'(k));
    check("R9 serial overwrite", 8'h3C);

    // Constrained random: write and hold weighted heavier
    for (int i = 0; i < 400; i++) begin
      int unsigned pick;
      logic c, e;
      pick = $urandom_range(0, 9);
      if (pick < 1)      begin c = 1'b0; e = 1'b1; end
      else if (pick < 3) begin c = 1'b0; e = 1'b0; end
      else if (pick < 7) begin c = 1'b1; e = 1'b0; end
      else               begin c = 1'b1; e = 1'b1; end
      step(c, e, 1'($urandom_range(0, 1)), SEL_W'($urandom_range(0, WIDTH - 1)));
      check(modeTag(c, e), model);
    end

    finishRun();
  end

endmodule